// File: doc/BRIEF.md
# Power-Stage Fault and Soft-Start Sequencer

This block sequences start-up and fault handling for a multiphase buck regulator. All of its timing is counted in PWM switching periods, marked by a one-clock `pwm_tick` pulse, so every wait and ramp scales with the switching frequency. Its inputs are digitized comparator flags for over-voltage, under-voltage and averaged over-current, and it runs from the power-on reset.

After reset every phase is held in three-state for a short initial wait, then a soft-start ramp runs. During the ramp the block raises a ramp enable and exposes a step index that the reference generator follows. Once the ramp completes, the regulator is in normal operation and power-good can assert.

An over-current flag stops switching at once and starts a hiccup retry. Each retry has a much longer wait before the ramp is attempted again. An over-voltage flag latches a crowbar state that only reset clears. In that state the outputs are pulled low while the flag is high and are three-stated while it is low. Under-voltage only lowers power-good. All outputs are control pins with no handshake.

Top module: `pss_seq`

## Requirements
- R1: While `por_n` is low, every phase drives three-state (2'b10), `ramp_en` and `ramp_step` are 0 and `power_good` is 0, whatever the fault flags and ticks do; after release the block starts in its initial wait with no fault remembered. Drive codes per 2-bit lane: 2'b00 normal PWM, 2'b01 forced low, 2'b10 three-state; lane p sits at bits [2p+1:2p] and all lanes always carry the same code.
- R2: After reset release the outputs stay three-state for exactly INIT_WAIT ticks; the clock after the INIT_WAIT-th tick, `ramp_en` is 1 with `ramp_step` 0.
- R3: The ramp lasts RAMP_LEN ticks with drive 2'b00; `ramp_step` equals the number of ticks taken since the ramp began (0 to RAMP_LEN-1), changes only on a tick, and is 0 whenever `ramp_en` is 0.
- R4: The clock after the RAMP_LEN-th ramp tick, `ramp_en` drops, drive stays 2'b00 and `power_good` is 1 when no flag is set.
- R5: An over-current flag sampled during ramp or normal operation makes all phases three-state with `ramp_en` and `power_good` low from the next clock. The wait that follows lasts RETRY_WAIT ticks, and the ramp then restarts. Over-current during a wait is ignored.
- R6: With over-current held, each wait of RETRY_WAIT ticks is followed by a ramp that lasts one clock before the next wait begins, indefinitely.
- R7: An over-voltage flag sampled in any state out of reset latches a crowbar state from the next clock. In that state drive is never 2'b00 and `ramp_en` and `power_good` stay 0, and ticks and over-current have no effect. Only reset clears it.
- R8: In the crowbar state drive follows the over-voltage flag in the same cycle: 2'b01 while it is high, 2'b10 while it is low.
- R9: When over-voltage and over-current are sampled at the same edge, the crowbar state wins.
- R10: Under-voltage pulls `power_good` low in the same cycle, does not change drive or sequencing, and is not remembered once it clears.
- R11: `power_good` is 1 only in normal operation with no over-voltage, under-voltage or over-current flag set in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pwm_tick | input | 1 | One-clock pulse per PWM switching period |
| ov_flag | input | 1 | Over-voltage comparator flag (hysteresis applied upstream) |
| uv_flag | input | 1 | Under-voltage comparator flag |
| oc_flag | input | 1 | Averaged over-current comparator flag |
| drive_mode | output | 2*NUM_PHASES | Per-phase drive code, 2 bits per phase |
| ramp_en | output | 1 | Soft-start ramp in progress |
| ramp_step | output | STEP_W | Ramp step index |
| power_good | output | 1 | Output voltage in range and start-up complete |

## Verification
The bench counts ticks to confirm the exact wait and ramp lengths, both for the first start and for retries. A design that reused the short wait after over-current, or dropped the retry length after a hiccup, would enter the ramp several ticks early. Held over-current must produce a one-clock ramp each round; a design that ignored over-current once in the ramp would finish the start-up instead. The bench also drives over-voltage and over-current together and then toggles over-voltage alone. A design that gave over-current priority, or let ticks or reset-time flags bring it out of the crowbar state, would resume switching or show normal drive where low or three-state is expected.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    DRV_PWM = 2'b00,
    DRV_LOW = 2'b01,
    DRV_HIZ = 2'b10
  } drive_e;

  typedef enum logic [1:0] {
    SQ_WAIT,
    SQ_RAMP,
    SQ_RUN,
    SQ_CROWBAR
  } seq_e;
endpackage

// File: rtl/pss_cycle_timer.sv
module pss_cycle_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (clr)
      count <= '0;
    else if (run && tick)
      count <= count + CNT_W'(1);
  end

  // terminal tick of the current interval
  assign done = run && tick && (count == limit - CNT_W'(1));
endmodule

// File: rtl/pss_seq_fsm.sv
module pss_seq_fsm
  import pss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ov_flag,
  input  logic oc_flag,
  input  logic span_done,
  output seq_e state,
  output logic retry,
  output logic timer_clr
);
  seq_e nxt;
  logic retry_nxt;

  always_comb begin
    nxt = state;
    if (state != SQ_CROWBAR) begin
      if (ov_flag) begin
        nxt = SQ_CROWBAR;
      end else begin
        case (state)
          SQ_WAIT: if (span_done) nxt = SQ_RAMP;
          SQ_RAMP: begin
            if (oc_flag)        nxt = SQ_WAIT;
            else if (span_done) nxt = SQ_RUN;
          end
          SQ_RUN:  if (oc_flag) nxt = SQ_WAIT;
          default: nxt = state;
        endcase
      end
    end
  end

  // once an over-current trip has happened, every later wait is the long one
  assign retry_nxt = retry ||
                     (oc_flag && !ov_flag && (state == SQ_RAMP || state == SQ_RUN));
  assign timer_clr = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_WAIT;
      retry <= 1'b0;
    end else begin
      state <= nxt;
      retry <= retry_nxt;
    end
  end
endmodule

// File: rtl/pss_out_decode.sv
module pss_out_decode
  import pss_pkg::*;
#(
  parameter int NUM_PHASES = 4,
  parameter int CNT_W      = 12,
  parameter int STEP_W     = 11
) (
  input  seq_e                      state,
  input  logic                      ov_flag,
  input  logic                      uv_flag,
  input  logic                      oc_flag,
  input  logic [CNT_W-1:0]          count,
  output logic [2*NUM_PHASES-1:0]   drive_mode,
  output logic                      ramp_en,
  output logic [STEP_W-1:0]         ramp_step,
  output logic                      power_good
);
  drive_e mode;

  always_comb begin
    case (state)
      SQ_RAMP, SQ_RUN: mode = DRV_PWM;
      SQ_CROWBAR:      mode = ov_flag ? DRV_LOW : DRV_HIZ;
      default:         mode = DRV_HIZ;
    endcase
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_lane
    assign drive_mode[2*g +: 2] = mode;
  end

  assign ramp_en    = (state == SQ_RAMP);
  assign ramp_step  = ramp_en ? STEP_W'(count) : '0;
  assign power_good = (state == SQ_RUN) && !ov_flag && !uv_flag && !oc_flag;
endmodule

// File: rtl/pss_seq.sv
module pss_seq
  import pss_pkg::*;
#(
  parameter int NUM_PHASES = 4,
  parameter int INIT_WAIT  = 32,
  parameter int RETRY_WAIT = 2048,
  parameter int RAMP_LEN   = 2016,
  localparam int MAX_A     = (INIT_WAIT > RETRY_WAIT) ? INIT_WAIT : RETRY_WAIT,
  localparam int MAX_LEN   = (MAX_A > RAMP_LEN) ? MAX_A : RAMP_LEN,
  localparam int CNT_W     = $clog2(MAX_LEN + 1),
  localparam int STEP_W    = (RAMP_LEN > 1) ? $clog2(RAMP_LEN) : 1
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    pwm_tick,
  input  logic                    ov_flag,
  input  logic                    uv_flag,
  input  logic                    oc_flag,
  output logic [2*NUM_PHASES-1:0] drive_mode,
  output logic                    ramp_en,
  output logic [STEP_W-1:0]       ramp_step,
  output logic                    power_good
);
  seq_e             state;
  logic             retry;
  logic             timer_clr;
  logic             span_done;
  logic             timer_run;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] count;

  always_comb begin
    if (state == SQ_WAIT)
      limit = retry ? CNT_W'(RETRY_WAIT) : CNT_W'(INIT_WAIT);
    else
      limit = CNT_W'(RAMP_LEN);
  end

  assign timer_run = (state == SQ_WAIT) || (state == SQ_RAMP);

  pss_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (por_n),
    .clr   (timer_clr),
    .run   (timer_run),
    .tick  (pwm_tick),
    .limit (limit),
    .count (count),
    .done  (span_done)
  );

  pss_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (por_n),
    .ov_flag   (ov_flag),
    .oc_flag   (oc_flag),
    .span_done (span_done),
    .state     (state),
    .retry     (retry),
    .timer_clr (timer_clr)
  );

  pss_out_decode #(
    .NUM_PHASES (NUM_PHASES),
    .CNT_W      (CNT_W),
    .STEP_W     (STEP_W)
  ) u_dec (
    .state      (state),
    .ov_flag    (ov_flag),
    .uv_flag    (uv_flag),
    .oc_flag    (oc_flag),
    .count      (count),
    .drive_mode (drive_mode),
    .ramp_en    (ramp_en),
    .ramp_step  (ramp_step),
    .power_good (power_good)
  );
endmodule

// File: rtl/pss_seq_chk.sv
module pss_seq_chk #(
  parameter int NUM_PHASES = 4,
  parameter int RAMP_LEN   = 2016,
  parameter int STEP_W     = 11
) (
  input logic                    clk,
  input logic                    por_n,
  input logic                    pwm_tick,
  input logic                    ov_flag,
  input logic                    uv_flag,
  input logic                    oc_flag,
  input logic [2*NUM_PHASES-1:0] drive_mode,
  input logic                    ramp_en,
  input logic [STEP_W-1:0]       ramp_step,
  input logic                    power_good
);
  logic       past_ok;
  logic [1:0] lane0;

  assign lane0 = drive_mode[1:0];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  lanes_legal_chk: assert property (@(posedge clk) disable iff (!por_n)
    (drive_mode == {NUM_PHASES{lane0}}) && (lane0 != 2'b11));

  // R3
  step_range_chk: assert property (@(posedge clk) disable iff (!por_n)
    ramp_en |-> ({1'b0, ramp_step} < (STEP_W+1)'(RAMP_LEN)));

  // R3
  step_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    !ramp_en |-> (ramp_step == '0));

  // R3
  step_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (past_ok && ramp_en && $past(ramp_en) && !$past(pwm_tick)) |-> $stable(ramp_step));

  // R5
  oc_stop_chk: assert property (@(posedge clk) disable iff (!por_n)
    (past_ok && oc_flag && !ov_flag && lane0 == 2'b00)
      |=> (lane0 == 2'b10 && !ramp_en && !power_good));

  // R7
  ov_trip_chk: assert property (@(posedge clk) disable iff (!por_n)
    (past_ok && ov_flag) |=> (lane0 != 2'b00 && !ramp_en && !power_good));

  // R7
  crowbar_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (past_ok && lane0 == 2'b01) |=> (lane0 != 2'b00 && !ramp_en && !power_good));

  // R11
  pgood_clean_chk: assert property (@(posedge clk) disable iff (!por_n)
    power_good |-> (lane0 == 2'b00 && !ov_flag && !uv_flag && !oc_flag && !ramp_en));
endmodule

bind pss_seq pss_seq_chk #(
  .NUM_PHASES (NUM_PHASES),
  .RAMP_LEN   (RAMP_LEN),
  .STEP_W     (STEP_W)
) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .pwm_tick   (pwm_tick),
  .ov_flag    (ov_flag),
  .uv_flag    (uv_flag),
  .oc_flag    (oc_flag),
  .drive_mode (drive_mode),
  .ramp_en    (ramp_en),
  .ramp_step  (ramp_step),
  .power_good (power_good)
);

// File: tb/sim_pss_seq.sv
`timescale 1ns/1ps
module sim_pss_seq;
  localparam int NPH    = 3;
  localparam int INIT   = 4;
  localparam int RETRY  = 12;
  localparam int RAMP   = 6;
  localparam int STEP_W = $clog2(RAMP);
  localparam int PWM = 0, LOW = 1, HIZ = 2;

  logic              clk = 1'b0;
  logic              por_n = 1'b0;
  logic              pwm_tick = 1'b0;
  logic              ov_flag = 1'b0;
  logic              uv_flag = 1'b0;
  logic              oc_flag = 1'b0;
  logic [2*NPH-1:0]  drive_mode;
  logic              ramp_en;
  logic [STEP_W-1:0] ramp_step;
  logic              power_good;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pss_seq #(
    .NUM_PHASES (NPH),
    .INIT_WAIT  (INIT),
    .RETRY_WAIT (RETRY),
    .RAMP_LEN   (RAMP)
  ) u0 (
    .clk        (clk),
    .por_n      (por_n),
    .pwm_tick   (pwm_tick),
    .ov_flag    (ov_flag),
    .uv_flag    (uv_flag),
    .oc_flag    (oc_flag),
    .drive_mode (drive_mode),
    .ramp_en    (ramp_en),
    .ramp_step  (ramp_step),
    .power_good (power_good)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input int drv, input int ren,
                         input int step, input int pg);
    int e;
    e = 0;
    for (int p = 0; p < NPH; p++) e = e | (drv << (2*p));
    chk({tag, " drive"}, int'(drive_mode), e);
    chk({tag, " ramp_en"}, int'(ramp_en), ren);
    chk({tag, " step"}, int'(ramp_step), step);
    chk({tag, " pgood"}, int'(power_good), pg);
  endtask

  // one tick pulse across exactly one rising edge; returns at the next falling edge
  task automatic tick();
    @(negedge clk) pwm_tick = 1'b1;
    @(negedge clk) pwm_tick = 1'b0;
  endtask

  task automatic startup(input string wtag, input int wlen);
    for (int n = 1; n <= wlen + RAMP + 1; n++) begin
      tick();
      if (n < wlen)             chk_out(wtag, HIZ, 0, 0, 0);
      else if (n < wlen + RAMP) chk_out("R3 ramp", PWM, 1, n - wlen, 0);
      else                      chk_out("R4 run", PWM, 0, 0, 1);
    end
  endtask

  initial begin
    // R1: reset holds outputs, flags and ticks ignored
    ov_flag = 1'b1; oc_flag = 1'b1; uv_flag = 1'b1;
    repeat (3) tick();
    chk_out("R1 in reset", HIZ, 0, 0, 0);
    @(negedge clk) begin ov_flag = 0; oc_flag = 0; uv_flag = 0; end
    @(negedge clk) por_n = 1'b1;
    @(negedge clk);
    chk_out("R1 after release", HIZ, 0, 0, 0);
    startup("R2 init wait", INIT);

    // R10: under-voltage only lowers power-good
    @(negedge clk) uv_flag = 1'b1;
    #1 chk_out("R10 uv high", PWM, 0, 0, 0);
    repeat (3) tick();
    chk_out("R10 uv held", PWM, 0, 0, 0);
    @(negedge clk) uv_flag = 1'b0;
    #1 chk_out("R10 uv cleared", PWM, 0, 0, 1);

    // R5: over-current in run, then long wait
    @(negedge clk) oc_flag = 1'b1;
    #1 chk("R11 pgood with oc", int'(power_good), 0);
    @(negedge clk) oc_flag = 1'b0;
    #1 chk_out("R5 oc stop", HIZ, 0, 0, 0);
    startup("R5 retry wait", RETRY);

    // R5: over-current mid-ramp, then oc during wait is ignored
    @(negedge clk) oc_flag = 1'b1;
    @(negedge clk) oc_flag = 1'b0;
    repeat (RETRY + 2) tick();
    chk_out("R5 mid ramp", PWM, 1, 2, 0);
    @(negedge clk) oc_flag = 1'b1;
    @(negedge clk) chk_out("R5 ramp abort", HIZ, 0, 0, 0);
    repeat (3) tick();
    oc_flag = 1'b0;
    repeat (RETRY - 4) tick();
    chk_out("R5 wait not done", HIZ, 0, 0, 0);
    tick();
    chk_out("R5 wait done", PWM, 1, 0, 0);
    repeat (RAMP) tick();
    chk_out("R4 run again", PWM, 0, 0, 1);

    // R6: held over-current gives repeated one-clock ramps
    @(negedge clk) oc_flag = 1'b1;
    @(negedge clk) chk_out("R6 trip", HIZ, 0, 0, 0);
    for (int r = 0; r < 3; r++) begin
      repeat (RETRY - 1) tick();
      chk_out("R6 waiting", HIZ, 0, 0, 0);
      tick();
      chk_out("R6 ramp try", PWM, 1, 0, 0);
      @(negedge clk);
      chk_out("R6 back to wait", HIZ, 0, 0, 0);
    end
    oc_flag = 1'b0;
    startup("R6 recover wait", RETRY);

    // R9 + R8 + R7: simultaneous faults, crowbar follows ov flag
    @(negedge clk) begin ov_flag = 1'b1; oc_flag = 1'b1; end
    @(negedge clk) chk_out("R9 ov wins", LOW, 0, 0, 0);
    oc_flag = 1'b0; ov_flag = 1'b0;
    #1 chk_out("R8 ov low", HIZ, 0, 0, 0);
    @(negedge clk) ov_flag = 1'b1;
    #1 chk_out("R8 ov high", LOW, 0, 0, 0);
    @(negedge clk) ov_flag = 1'b0;
    repeat (RETRY + RAMP + 4) tick();
    chk_out("R7 latched vs ticks", HIZ, 0, 0, 0);
    @(negedge clk) oc_flag = 1'b1;
    @(negedge clk) oc_flag = 1'b0;
    repeat (INIT + 1) tick();
    chk_out("R7 latched vs oc", HIZ, 0, 0, 0);

    // R7: reset clears; over-voltage during initial wait latches too
    @(negedge clk) por_n = 1'b0;
    @(negedge clk) por_n = 1'b1;
    @(negedge clk) chk_out("R7 cleared", HIZ, 0, 0, 0);
    repeat (2) tick();
    @(negedge clk) ov_flag = 1'b1;
    @(negedge clk) ov_flag = 1'b0;
    repeat (INIT + 2) tick();
    chk_out("R7 wait latch", HIZ, 0, 0, 0);
    @(negedge clk) ov_flag = 1'b1;
    #1 chk_out("R8 wait latch low", LOW, 0, 0, 0);
    @(negedge clk) ov_flag = 1'b0;

    // R2: a fresh reset uses the short wait again
    @(negedge clk) por_n = 1'b0;
    @(negedge clk) por_n = 1'b1;
    @(negedge clk);
    startup("R2 second start", INIT);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule